// File: doc/BRIEF.md
# Self-Routing Shuffle-Exchange Switching Fabric

This block moves one data word from each of eight input ports to the output port named by a 3-bit destination address carried with the word. The fabric is three ranks of 2x2 switching cells. In front of every rank, fixed wiring rotates each lane index left by one bit. Each cell steers itself from a single destination bit: the first rank uses the most significant bit and the last rank uses the least significant bit. The cells need no central controller and no table.

Each rank ends in a register, so a word presented at the inputs appears at the outputs three clock cycles later. A new set of words may be presented in every cycle. The fabric can block. Two words that reach the same cell and ask for the same cell output cannot both pass. In that case the word on the cell's upper input goes through, the word on the lower input is discarded, and that rank's conflict bit is raised for one cycle. A word travelling alone always reaches its destination.

Top module: `omega_fabric`

## Requirements
- R1: While rst_n is low, and on the first cycle after it, every out_valid bit, every out_data bit and every conflict bit is 0.
- R2: A single valid word presented on input s with destination d, in an otherwise idle fabric, appears on output port d exactly 3 clock edges later with its data unchanged. This holds for all 64 (s, d) pairs.
- R3: Steering follows the destination bits. Rank k uses destination bit 2-k. A value of 0 selects the cell's upper output (the even lane) and a value of 1 selects the lower output (the odd lane). Before every rank, the word on lane q moves to lane {q[1:0], q[2]}. A valid output on port p always carries destination p.
- R4: Any output port whose out_valid is 0 drives out_data equal to 0.
- R5: When both inputs of a cell are valid and request the same cell output, the upper input's word is forwarded and the lower input's word is discarded. Bit k of conflict (rank k) is then 1 for exactly one cycle, k+1 edges after the words entered the fabric.
- R6: The identity permutation (input i to port i) and the rotate-by-one permutation (input i to port (i+1) mod 8) deliver all eight words with no conflict bit set.
- R7: No word is duplicated. In every rank, the number of valid words leaving equals the number that entered minus the number of conflicts in that rank.
- R8: Word sets presented on consecutive cycles travel independently. Each one produces its outputs 3 cycles after its own entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | N_PORTS (8) | Bit i marks a word present on input i |
| in_dest | input | N_PORTS*ADDR_W (24) | Destination of input i at bits [3i+2:3i] |
| in_data | input | N_PORTS*DATA_W (128) | Data of input i at bits [16i+15:16i] |
| out_valid | output | N_PORTS (8) | Bit p marks a word delivered on output p |
| out_data | output | N_PORTS*DATA_W (128) | Data of output p at bits [16p+15:16p], zero when idle |
| conflict | output | STAGES (3) | Bit k: a word was discarded in rank k |

## Verification
The word-count property in each rank compares that rank's registered valid and conflict bits against its valid inputs one edge earlier. It therefore assumes that in_valid is held at 0 while rst_n is low. The bench drives every input to 0 before reset and releases reset at a falling edge. The routing and idle-zero properties assume nothing about the inputs. The bench still changes in_valid, in_dest and in_data only at falling edges, so each word set is seen by exactly one rising edge.

// File: rtl/omega_pkg.sv
package omega_pkg;

    // Setting of one 2x2 switching cell
    typedef enum logic {
        XS_STRAIGHT = 1'b0,
        XS_CROSSED  = 1'b1
    } xs_state_e;

    // Lane index after the inter-rank wiring: rotate left by one bit
    function automatic int unsigned lane_rotl(input int unsigned idx, input int unsigned bits);
        int unsigned mask;
        mask = (32'd1 << bits) - 32'd1;
        return ((idx << 1) | (idx >> (bits - 1))) & mask;
    endfunction

endpackage

// File: rtl/omega_xchg.sv
module omega_xchg
    import omega_pkg::*;
#(
    parameter int ADDR_W  = 3,
    parameter int DATA_W  = 16,
    parameter int BIT_SEL = 2
) (
    input  logic              top_vld,
    input  logic [ADDR_W-1:0] top_dst,
    input  logic [DATA_W-1:0] top_dat,
    input  logic              bot_vld,
    input  logic [ADDR_W-1:0] bot_dst,
    input  logic [DATA_W-1:0] bot_dat,
    output logic              up_vld,
    output logic [ADDR_W-1:0] up_dst,
    output logic [DATA_W-1:0] up_dat,
    output logic              lo_vld,
    output logic [ADDR_W-1:0] lo_dst,
    output logic [DATA_W-1:0] lo_dat,
    output logic              clash
);

    logic      top_wants_lo, bot_wants_lo;
    logic      top_to_up, bot_to_up, top_to_lo, bot_to_lo;
    xs_state_e sw;

    always_comb begin
        top_wants_lo = top_dst[BIT_SEL];
        bot_wants_lo = bot_dst[BIT_SEL];
        // upper input holds priority on either output
        top_to_up = top_vld & ~top_wants_lo;
        top_to_lo = top_vld &  top_wants_lo;
        bot_to_up = bot_vld & ~bot_wants_lo & ~top_to_up;
        bot_to_lo = bot_vld &  bot_wants_lo & ~top_to_lo;
        clash     = top_vld & bot_vld & (top_wants_lo == bot_wants_lo);
        sw        = (top_to_lo | bot_to_up) ? XS_CROSSED : XS_STRAIGHT;

        if (sw == XS_STRAIGHT) begin
            up_vld = top_to_up;
            up_dst = top_to_up ? top_dst : '0;
            up_dat = top_to_up ? top_dat : '0;
            lo_vld = bot_to_lo;
            lo_dst = bot_to_lo ? bot_dst : '0;
            lo_dat = bot_to_lo ? bot_dat : '0;
        end else begin
            up_vld = bot_to_up;
            up_dst = bot_to_up ? bot_dst : '0;
            up_dat = bot_to_up ? bot_dat : '0;
            lo_vld = top_to_lo;
            lo_dst = top_to_lo ? top_dst : '0;
            lo_dat = top_to_lo ? top_dat : '0;
        end
    end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
    import omega_pkg::*;
#(
    parameter int N_PORTS   = 8,
    parameter int ADDR_W    = 3,
    parameter int DATA_W    = 16,
    parameter int STAGE_IDX = 0
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PORTS-1:0]         in_vld,
    input  logic [N_PORTS*ADDR_W-1:0]  in_dst,
    input  logic [N_PORTS*DATA_W-1:0]  in_dat,
    output logic [N_PORTS-1:0]         out_vld,
    output logic [N_PORTS*ADDR_W-1:0]  out_dst,
    output logic [N_PORTS*DATA_W-1:0]  out_dat,
    output logic                       clash_o
);

    localparam int CELLS   = N_PORTS / 2;
    localparam int BIT_SEL = ADDR_W - 1 - STAGE_IDX;

    typedef struct packed {
        logic [N_PORTS-1:0]        vld;
        logic [N_PORTS*ADDR_W-1:0] dst;
        logic [N_PORTS*DATA_W-1:0] dat;
        logic [CELLS-1:0]          clash;
    } rank_t;

    rank_t st_d, st_q;

    logic [N_PORTS-1:0]        sh_vld, el_vld;
    logic [N_PORTS*ADDR_W-1:0] sh_dst, el_dst;
    logic [N_PORTS*DATA_W-1:0] sh_dat, el_dat;
    logic [CELLS-1:0]          el_clash;

    // inter-rank wiring
    for (genvar q = 0; q < N_PORTS; q++) begin : g_wire
        localparam int unsigned P = lane_rotl(q, ADDR_W);
        assign sh_vld[P]                   = in_vld[q];
        assign sh_dst[P*ADDR_W +: ADDR_W]  = in_dst[q*ADDR_W +: ADDR_W];
        assign sh_dat[P*DATA_W +: DATA_W]  = in_dat[q*DATA_W +: DATA_W];
    end

    for (genvar e = 0; e < CELLS; e++) begin : g_cell
        omega_xchg #(
            .ADDR_W (ADDR_W),
            .DATA_W (DATA_W),
            .BIT_SEL(BIT_SEL)
        ) i_xchg (
            .top_vld(sh_vld[2*e]),
            .top_dst(sh_dst[(2*e)*ADDR_W +: ADDR_W]),
            .top_dat(sh_dat[(2*e)*DATA_W +: DATA_W]),
            .bot_vld(sh_vld[2*e+1]),
            .bot_dst(sh_dst[(2*e+1)*ADDR_W +: ADDR_W]),
            .bot_dat(sh_dat[(2*e+1)*DATA_W +: DATA_W]),
            .up_vld (el_vld[2*e]),
            .up_dst (el_dst[(2*e)*ADDR_W +: ADDR_W]),
            .up_dat (el_dat[(2*e)*DATA_W +: DATA_W]),
            .lo_vld (el_vld[2*e+1]),
            .lo_dst (el_dst[(2*e+1)*ADDR_W +: ADDR_W]),
            .lo_dat (el_dat[(2*e+1)*DATA_W +: DATA_W]),
            .clash  (el_clash[e])
        );
    end

    always_comb begin
        st_d       = st_q;
        st_d.vld   = el_vld;
        st_d.dst   = el_dst;
        st_d.dat   = el_dat;
        st_d.clash = el_clash;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_vld = st_q.vld;
    assign out_dst = st_q.dst;
    assign out_dat = st_q.dat;
    assign clash_o = |st_q.clash;

    // R7: words are neither created nor duplicated in this rank
    p_conserve_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(st_q.vld) + $countones(st_q.clash)) == $past($countones(in_vld)));

    for (genvar e = 0; e < CELLS; e++) begin : g_chk
        // R5: a clash leaves exactly one survivor on the cell's two outputs
        p_clash_survivor_r5: assert property (@(posedge clk) disable iff (!rst_n)
            st_q.clash[e] |-> ($countones(st_q.vld[2*e+1 -: 2]) == 1));
    end

endmodule

// File: rtl/omega_fabric.sv
module omega_fabric
    import omega_pkg::*;
#(
    parameter int N_PORTS = 8,
    parameter int DATA_W  = 16,
    parameter int ADDR_W  = $clog2(N_PORTS),
    parameter int STAGES  = ADDR_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_PORTS-1:0]         in_valid,
    input  logic [N_PORTS*ADDR_W-1:0]  in_dest,
    input  logic [N_PORTS*DATA_W-1:0]  in_data,
    output logic [N_PORTS-1:0]         out_valid,
    output logic [N_PORTS*DATA_W-1:0]  out_data,
    output logic [STAGES-1:0]          conflict
);

    logic [N_PORTS-1:0]        vld_w [0:STAGES];
    logic [N_PORTS*ADDR_W-1:0] dst_w [0:STAGES];
    logic [N_PORTS*DATA_W-1:0] dat_w [0:STAGES];

    assign vld_w[0] = in_valid;
    assign dst_w[0] = in_dest;
    assign dat_w[0] = in_data;

    for (genvar s = 0; s < STAGES; s++) begin : g_rank
        omega_stage #(
            .N_PORTS  (N_PORTS),
            .ADDR_W   (ADDR_W),
            .DATA_W   (DATA_W),
            .STAGE_IDX(s)
        ) i_stage (
            .clk    (clk),
            .rst_n  (rst_n),
            .in_vld (vld_w[s]),
            .in_dst (dst_w[s]),
            .in_dat (dat_w[s]),
            .out_vld(vld_w[s+1]),
            .out_dst(dst_w[s+1]),
            .out_dat(dat_w[s+1]),
            .clash_o(conflict[s])
        );
    end

    assign out_valid = vld_w[STAGES];
    assign out_data  = dat_w[STAGES];

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port_chk
        // R3: a delivered word sits on the port it addressed
        p_route_r3: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] |-> (dst_w[STAGES][p*ADDR_W +: ADDR_W] == ADDR_W'(p)));
        // R4: an idle output carries zero data
        p_idle_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !out_valid[p] |-> (out_data[p*DATA_W +: DATA_W] == '0));
    end

endmodule

// File: tb/test_omega_fabric.sv
module test_omega_fabric;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int AW = 3;
    localparam int DW = 16;
    localparam int ST = 3;
    localparam int LAT = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [NP-1:0]     in_valid = '0;
    logic [NP*AW-1:0]  in_dest = '0;
    logic [NP*DW-1:0]  in_data = '0;
    logic [NP-1:0]     out_valid;
    logic [NP*DW-1:0]  out_data;
    logic [ST-1:0]     conflict;

    omega_fabric #(.N_PORTS(NP), .DATA_W(DW)) i_omega_fabric (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_dest(in_dest),
        .in_data(in_data), .out_valid(out_valid), .out_data(out_data), .conflict(conflict)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        int          due;
        int          port;
        logic [DW-1:0] dat;
        string       tag;
    } exp_t;

    exp_t       sbq[$];
    logic [ST-1:0] exp_cnf [0:1023];
    int  cyc = 0;
    int  n_chk = 0;
    int  n_bad = 0;
    bit  mon_en = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input string what,
                       input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s cyc=%0d actual=%0h expected=%0h", tag, what, cyc, act, expv);
        end
    endtask

    task automatic drive(input logic [NP-1:0] v, input logic [NP*AW-1:0] dd,
                         input logic [NP*DW-1:0] dt, output int c0);
        @(negedge clk);
        in_valid = v;
        in_dest  = dd;
        in_data  = dt;
        c0 = cyc;
    endtask

    task automatic push(input int due, input int port, input logic [DW-1:0] dat, input string tag);
        exp_t it;
        it.due = due; it.port = port; it.dat = dat; it.tag = tag;
        sbq.push_back(it);
    endtask

    // monitor: compares every port and the conflict bits once per cycle
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            logic [NP-1:0] ev;
            logic [DW-1:0] ed [NP];
            string         et [NP];
            ev = '0;
            for (int p = 0; p < NP; p++) begin ed[p] = '0; et[p] = "R4"; end
            while (sbq.size() > 0 && sbq[0].due <= cyc) begin
                exp_t it;
                it = sbq.pop_front();
                if (it.due < cyc) chk(1'b0, it.tag, "stale expectation", it.due, cyc);
                ev[it.port] = 1'b1;
                ed[it.port] = it.dat;
                et[it.port] = it.tag;
            end
            for (int p = 0; p < NP; p++) begin
                chk(out_valid[p] == ev[p], et[p], $sformatf("out_valid[%0d]", p),
                    out_valid[p], ev[p]);
                chk(out_data[p*DW +: DW] == ed[p], et[p], $sformatf("out_data[%0d]", p),
                    out_data[p*DW +: DW], ed[p]);
            end
            chk(conflict == exp_cnf[cyc], "R5", "conflict", conflict, exp_cnf[cyc]);
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        int c0;
        logic [NP-1:0]    v;
        logic [NP*AW-1:0] dd;
        logic [NP*DW-1:0] dt;

        for (int i = 0; i < 1024; i++) exp_cnf[i] = '0;

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(out_valid == '0, "R1", "out_valid in reset", out_valid, 0);
        chk(out_data == '0, "R1", "out_data in reset", out_data[63:0], 0);
        chk(conflict == '0, "R1", "conflict in reset", conflict, 0);
        rst_n = 1'b1;
        mon_en = 1'b1;
        @(negedge clk);
        chk(out_valid == '0 && conflict == '0, "R1", "first cycle after reset",
            {out_valid, conflict}, 0);

        // R2 and R8: every lone source/destination pair, back to back
        for (int s = 0; s < NP; s++) begin
            for (int d = 0; d < NP; d++) begin
                v = '0; dd = '0; dt = '0;
                v[s] = 1'b1;
                dd[s*AW +: AW] = AW'(d);
                dt[s*DW +: DW] = 16'hA000 | 16'(s << 4) | 16'(d);
                drive(v, dd, dt, c0);
                push(c0 + LAT, d, 16'hA000 | 16'(s << 4) | 16'(d), "R2 R8");
            end
        end
        drive('0, '0, '0, c0);
        repeat (4) @(negedge clk);

        // R6: identity permutation
        v = '1; dd = '0; dt = '0;
        for (int i = 0; i < NP; i++) begin
            dd[i*AW +: AW] = AW'(i);
            dt[i*DW +: DW] = 16'hB000 | 16'(i);
        end
        drive(v, dd, dt, c0);
        for (int i = 0; i < NP; i++) push(c0 + LAT, i, 16'hB000 | 16'(i), "R6");

        // R6: rotate-by-one permutation, issued on the next cycle (R8)
        for (int i = 0; i < NP; i++) begin
            dd[i*AW +: AW] = AW'((i + 1) % NP);
            dt[i*DW +: DW] = 16'hC000 | 16'(i);
        end
        drive(v, dd, dt, c0);
        for (int i = 0; i < NP; i++) push(c0 + LAT, (i + 1) % NP, 16'hC000 | 16'(i), "R6 R8");
        drive('0, '0, '0, c0);
        repeat (4) @(negedge clk);

        // R5 R3: inputs 0 and 4 share the first-rank cell, both upper
        v = '0; dd = '0; dt = '0;
        v[0] = 1'b1; dd[0*AW +: AW] = 3'd0; dt[0*DW +: DW] = 16'hD100;
        v[4] = 1'b1; dd[4*AW +: AW] = 3'd1; dt[4*DW +: DW] = 16'hD104;
        drive(v, dd, dt, c0);
        push(c0 + LAT, 0, 16'hD100, "R5 R7");
        exp_cnf[c0 + 1] = exp_cnf[c0 + 1] | 3'b001;
        drive('0, '0, '0, c0);
        repeat (4) @(negedge clk);

        // R5: same cell, both lower; upper input wins and exits on port 4
        v = '0; dd = '0; dt = '0;
        v[0] = 1'b1; dd[0*AW +: AW] = 3'd4; dt[0*DW +: DW] = 16'hD200;
        v[4] = 1'b1; dd[4*AW +: AW] = 3'd5; dt[4*DW +: DW] = 16'hD204;
        drive(v, dd, dt, c0);
        push(c0 + LAT, 4, 16'hD200, "R5");
        exp_cnf[c0 + 1] = exp_cnf[c0 + 1] | 3'b001;
        drive('0, '0, '0, c0);
        repeat (4) @(negedge clk);

        // R3 R5: inputs 0 and 2 pass rank 0 apart and meet in rank 1
        v = '0; dd = '0; dt = '0;
        v[0] = 1'b1; dd[0*AW +: AW] = 3'd0; dt[0*DW +: DW] = 16'hD300;
        v[2] = 1'b1; dd[2*AW +: AW] = 3'd1; dt[2*DW +: DW] = 16'hD302;
        drive(v, dd, dt, c0);
        push(c0 + LAT, 0, 16'hD300, "R3 R5");
        exp_cnf[c0 + 2] = exp_cnf[c0 + 2] | 3'b010;
        drive('0, '0, '0, c0);
        repeat (6) @(negedge clk);

        chk(sbq.size() == 0, "R2", "expectations left over", sbq.size(), 0);
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule